// File: doc/BRIEF.md
# Infrared UART Interrupt Status Register

This block collects the interrupt sources of a multi-mode serial and infrared controller into one eight-bit status word. Its sources are a down-counting timer, the frame status queue, the transmit queue threshold, DMA terminal count, handshake line changes, UART line errors and frame-end detection. Each status bit keeps its own rule. Level bits follow a live condition. Sticky bits hold until this register is read. Other sticky bits hold until a companion status register is read.

Bit 2 takes a different meaning depending on the operating mode. In the plain UART and slow infrared modes it reports line errors. In the medium and fast infrared modes it reports frame end. In remote-control mode it is held at 0. Handshake change reporting is also gated by a separate enable whenever an infrared mode is active. A single interrupt line is formed from the status bits and an eight-bit enable word. The queues, the timer datapath, the DMA engine and the infrared physical layer are outside this block and appear only as strobes and levels.

Mode codes on `mode`: 0 UART, 1 SIR, 2 ASK-IR, 3 MIR, 4 FIR, 5 remote. Codes 6 and 7 behave like remote. Every status bit is a register, so each one reflects its inputs one clock after they are presented.

Top module: `irq_status_reg`

## Requirements
- R1: While `rst_n` is 0, and in the first cycle after it rises, `stat_q` is 8'h00 and `irq` is 0.
- R2: Bit 7 (timer) sets one cycle after `tmr_zero` when `tmr_run_en` and `tmr_irq_en` are both 1. A `tmr_zero` with either enable at 0 has no effect. The bit clears after `stat_rd`.
- R3: Bit 6 (frame status) is 1 one cycle after `fsf_level >= fsf_thresh`. An `fsf_timeout` pulse makes it pending until `stat_rd`. It is 0 when the level is below the threshold and no time-out is pending.
- R4: Bit 5 (transmit threshold) is 1 exactly when `tx_level < tx_thresh` held in the previous cycle. It drops once the level is at or above the threshold.
- R5: Bit 4 (DMA) sets after a pulse on `dma_tc_tx` or `dma_tc_rx` and clears after `stat_rd`.
- R6: Bit 3 (handshake) sets when `hs_value` differs from its value in the previous cycle. The first cycle after reset is never counted as a change. The bit clears after `hs_rd`, and `stat_rd` does not clear it.
- R7: In modes 1 to 7, a handshake change sets bit 3 only if `ir_hs_en` is 1. In mode 0 it always sets bit 3.
- R8: In modes 0, 1 and 2, bit 2 sets on any bit of `line_err` and clears after `usr_rd`. In these modes `stat_rd` leaves it unchanged.
- R9: In modes 3 and 4, bit 2 sets on `frame_end`, or on `frame_abort` while `rx_valid` is 1. It clears after `stat_rd`, and `usr_rd` leaves it unchanged. In modes 5 to 7, bit 2 reads 0.
- R10: Bit 1 follows `tx_empty` and bit 0 follows `rx_thresh`, each one cycle later.
- R11: `irq` is 1 exactly when some bit of `stat_q` is 1 and the same bit of `irq_en` is 1. It responds combinationally to `irq_en`.
- R12: A sticky bit or pending time-out that sees its set event in the same cycle as its clearing read stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 3 | Operating mode code |
| ir_hs_en | input | 1 | Allows handshake reporting in infrared modes |
| tmr_zero | input | 1 | Timer reached zero (strobe) |
| tmr_run_en | input | 1 | Timer running enable |
| tmr_irq_en | input | 1 | Timer interrupt enable |
| fsf_level | input | FSF_LVL_W | Frame status queue fill |
| fsf_thresh | input | FSF_LVL_W | Frame status queue threshold |
| fsf_timeout | input | 1 | Frame status time-out (strobe) |
| tx_level | input | TX_LVL_W | Transmit queue fill |
| tx_thresh | input | TX_LVL_W | Transmit queue threshold |
| dma_tc_tx | input | 1 | Transmit DMA terminal count (strobe) |
| dma_tc_rx | input | 1 | Receive DMA terminal count (strobe) |
| hs_value | input | HS_W | Handshake status word |
| hs_rd | input | 1 | Handshake status register read (strobe) |
| line_err | input | 4 | Overrun, parity, stop-bit, silent-byte errors |
| usr_rd | input | 1 | UART status register read (strobe) |
| frame_end | input | 1 | Proper frame end seen |
| frame_abort | input | 1 | Abort or illegal signal seen |
| rx_valid | input | 1 | Receiver inside valid data |
| tx_empty | input | 1 | Transmitter empty level |
| rx_thresh | input | 1 | Receiver threshold level |
| stat_rd | input | 1 | Read of this status register (strobe) |
| irq_en | input | 8 | Per-bit interrupt enables |
| stat_q | output | 8 | Interrupt status word |
| irq | output | 1 | Combined interrupt pending |

## Verification
The bench builds the block with 3-bit frame and transmit levels and a 2-bit handshake word. At these widths, random values regularly land exactly on the threshold, below it and above it. With only four handshake codes, a random redraw often repeats the old value, so cycles with a change and cycles without one both occur often. Mode changes during random runs move bit 2 across the error, frame-end and remote groups while it holds a value. This shows that a held bit follows the rules of the newly selected group.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;

  localparam int unsigned STAT_W = 8;

  localparam int unsigned B_TMR  = 7;
  localparam int unsigned B_FSF  = 6;
  localparam int unsigned B_TXTH = 5;
  localparam int unsigned B_DMA  = 4;
  localparam int unsigned B_HS   = 3;
  localparam int unsigned B_MIX  = 2;
  localparam int unsigned B_TXE  = 1;
  localparam int unsigned B_RXTH = 0;

  typedef enum logic [2:0] {
    MD_UART   = 3'd0,
    MD_SIR    = 3'd1,
    MD_ASK    = 3'd2,
    MD_MIR    = 3'd3,
    MD_FIR    = 3'd4,
    MD_REMOTE = 3'd5
  } op_mode_e;

  // line-error group: plain UART and slow infrared
  function automatic logic f_err_group(input logic [2:0] m);
    return (m <= 3'(MD_ASK));
  endfunction

  // frame-end group: medium and fast infrared
  function automatic logic f_frame_group(input logic [2:0] m);
    return (m == 3'(MD_MIR)) || (m == 3'(MD_FIR));
  endfunction

  function automatic logic f_any_ir(input logic [2:0] m);
    return (m != 3'(MD_UART));
  endfunction

  // shared bit 2: set wins over the group's own clearing read
  function automatic logic f_mix_next(input logic [2:0] m, input logic q,
                                      input logic err_ev, input logic usr_clr,
                                      input logic fend_ev, input logic own_clr);
    if (f_err_group(m))        return err_ev  | (q & ~usr_clr);
    else if (f_frame_group(m)) return fend_ev | (q & ~own_clr);
    else                       return 1'b0;
  endfunction

endpackage

// File: rtl/irq_sticky_bit.sv
module irq_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);

  p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);

endmodule

// File: rtl/irq_hs_toggle.sv
module irq_hs_toggle #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] value_i,
  output logic         toggle_o
);

  logic [W-1:0] prev_q;
  logic         armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= value_i;
      armed_q <= 1'b1;
    end
  end

  assign toggle_o = armed_q && (value_i != prev_q);

  p_toggle_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(value_i) |-> !toggle_o);

endmodule

// File: rtl/irq_lvl_cmp.sv
module irq_lvl_cmp #(
  parameter int unsigned W = 5
) (
  input  logic [W-1:0] level_i,
  input  logic [W-1:0] thr_i,
  output logic         at_or_above_o
);

  assign at_or_above_o = (level_i >= thr_i);

endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_stat_pkg::*;
#(
  parameter int unsigned FSF_LVL_W = 5,
  parameter int unsigned TX_LVL_W  = 5,
  parameter int unsigned HS_W      = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           mode,
  input  logic                 ir_hs_en,
  input  logic                 tmr_zero,
  input  logic                 tmr_run_en,
  input  logic                 tmr_irq_en,
  input  logic [FSF_LVL_W-1:0] fsf_level,
  input  logic [FSF_LVL_W-1:0] fsf_thresh,
  input  logic                 fsf_timeout,
  input  logic [TX_LVL_W-1:0]  tx_level,
  input  logic [TX_LVL_W-1:0]  tx_thresh,
  input  logic                 dma_tc_tx,
  input  logic                 dma_tc_rx,
  input  logic [HS_W-1:0]      hs_value,
  input  logic                 hs_rd,
  input  logic [3:0]           line_err,
  input  logic                 usr_rd,
  input  logic                 frame_end,
  input  logic                 frame_abort,
  input  logic                 rx_valid,
  input  logic                 tx_empty,
  input  logic                 rx_thresh,
  input  logic                 stat_rd,
  input  logic [7:0]           irq_en,
  output logic [7:0]           stat_q,
  output logic                 irq
);

  // named events for the assertions
  logic tmr_ev, dma_ev, hs_tog, hs_ev, err_ev, fend_ev;
  logic fsf_above, tx_at_or_above;
  logic tmr_q, dma_q, hs_q, to_q, to_next;
  logic fsf_q, txth_q, mix_q, txe_q, rxth_q;

  assign tmr_ev  = tmr_zero & tmr_run_en & tmr_irq_en;
  assign dma_ev  = dma_tc_tx | dma_tc_rx;
  assign hs_ev   = hs_tog & (~f_any_ir(mode) | ir_hs_en);
  assign err_ev  = |line_err;
  assign fend_ev = frame_end | (frame_abort & rx_valid);

  irq_lvl_cmp #(.W(FSF_LVL_W)) u_fsf_cmp (
    .level_i(fsf_level), .thr_i(fsf_thresh), .at_or_above_o(fsf_above));

  irq_lvl_cmp #(.W(TX_LVL_W)) u_tx_cmp (
    .level_i(tx_level), .thr_i(tx_thresh), .at_or_above_o(tx_at_or_above));

  irq_hs_toggle #(.W(HS_W)) u_hs_tog (
    .clk(clk), .rst_n(rst_n), .value_i(hs_value), .toggle_o(hs_tog));

  irq_sticky_bit u_tmr (.clk(clk), .rst_n(rst_n), .set_i(tmr_ev),
    .clr_i(stat_rd), .q_o(tmr_q));
  irq_sticky_bit u_dma (.clk(clk), .rst_n(rst_n), .set_i(dma_ev),
    .clr_i(stat_rd), .q_o(dma_q));
  irq_sticky_bit u_hs  (.clk(clk), .rst_n(rst_n), .set_i(hs_ev),
    .clr_i(hs_rd), .q_o(hs_q));
  irq_sticky_bit u_to  (.clk(clk), .rst_n(rst_n), .set_i(fsf_timeout),
    .clr_i(stat_rd), .q_o(to_q));

  // pending time-out as it will stand after this edge
  assign to_next = fsf_timeout | (to_q & ~stat_rd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsf_q  <= 1'b0;
      txth_q <= 1'b0;
      mix_q  <= 1'b0;
      txe_q  <= 1'b0;
      rxth_q <= 1'b0;
    end else begin
      fsf_q  <= fsf_above | to_next;
      txth_q <= ~tx_at_or_above;
      mix_q  <= f_mix_next(mode, mix_q, err_ev, usr_rd, fend_ev, stat_rd);
      txe_q  <= tx_empty;
      rxth_q <= rx_thresh;
    end
  end

  always_comb begin
    stat_q         = '0;
    stat_q[B_TMR]  = tmr_q;
    stat_q[B_FSF]  = fsf_q;
    stat_q[B_TXTH] = txth_q;
    stat_q[B_DMA]  = dma_q;
    stat_q[B_HS]   = hs_q;
    stat_q[B_MIX]  = mix_q;
    stat_q[B_TXE]  = txe_q;
    stat_q[B_RXTH] = rxth_q;
  end

  assign irq = |(stat_q & irq_en);

  p_tmr_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_zero && !(tmr_run_en && tmr_irq_en) && !stat_q[7]) |=> !stat_q[7]);

  p_fsf_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fsf_level >= fsf_thresh) |=> stat_q[6]);

  p_txth_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level < tx_thresh) |=> stat_q[5]);

  p_dma_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_tc_tx || dma_tc_rx) |=> stat_q[4]);

  p_hs_ir_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode != 3'd0) && !ir_hs_en && !stat_q[3]) |=> !stat_q[3]);

  p_usr_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode <= 3'd2) && stat_q[2] && !usr_rd) |=> stat_q[2]);

  p_remote_b2_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode >= 3'd5) |=> !stat_q[2]);

  p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == 8'h00) |-> !irq);

endmodule

// File: tb/sim_irq_status_reg.sv
module sim_irq_status_reg;

  localparam int FW = 3;
  localparam int TW = 3;
  localparam int HW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] mode;
  logic ir_hs_en, tmr_zero, tmr_run_en, tmr_irq_en, fsf_timeout;
  logic [FW-1:0] fsf_level, fsf_thresh;
  logic [TW-1:0] tx_level, tx_thresh;
  logic dma_tc_tx, dma_tc_rx, hs_rd, usr_rd, frame_end, frame_abort, rx_valid;
  logic [HW-1:0] hs_value;
  logic [3:0] line_err;
  logic tx_empty, rx_thresh, stat_rd;
  logic [7:0] irq_en, stat_q;
  logic irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // bench model state
  logic [7:0] e_stat;
  logic e_to, e_armed;
  logic [HW-1:0] e_prev;

  always #10 clk = ~clk; // 50 MHz

  irq_status_reg #(.FSF_LVL_W(FW), .TX_LVL_W(TW), .HS_W(HW)) u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .ir_hs_en(ir_hs_en),
    .tmr_zero(tmr_zero), .tmr_run_en(tmr_run_en), .tmr_irq_en(tmr_irq_en),
    .fsf_level(fsf_level), .fsf_thresh(fsf_thresh), .fsf_timeout(fsf_timeout),
    .tx_level(tx_level), .tx_thresh(tx_thresh), .dma_tc_tx(dma_tc_tx),
    .dma_tc_rx(dma_tc_rx), .hs_value(hs_value), .hs_rd(hs_rd),
    .line_err(line_err), .usr_rd(usr_rd), .frame_end(frame_end),
    .frame_abort(frame_abort), .rx_valid(rx_valid), .tx_empty(tx_empty),
    .rx_thresh(rx_thresh), .stat_rd(stat_rd), .irq_en(irq_en),
    .stat_q(stat_q), .irq(irq));

  function automatic string req_of(input int b);
    case (b)
      7: return "R2 timer";
      6: return "R3 frame-status";
      5: return "R4 tx-threshold";
      4: return "R5 dma";
      3: return "R6/R7 handshake";
      2: return "R8/R9 bit2";
      default: return "R10 level";
    endcase
  endfunction

  function automatic logic exp_irq(input logic [7:0] s, input logic [7:0] en);
    logic r = 1'b0;
    for (int i = 0; i < 8; i++) if (s[i] && en[i]) r = 1'b1;
    return r;
  endfunction

  task automatic check1(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic check_all();
    for (int b = 0; b < 8; b++) check1(req_of(b), stat_q[b], e_stat[b]);
    check1("R11 irq", irq, exp_irq(e_stat, irq_en));
  endtask

  task automatic quiet();
    tmr_zero = 0; fsf_timeout = 0; dma_tc_tx = 0; dma_tc_rx = 0;
    hs_rd = 0; usr_rd = 0; line_err = 0; frame_end = 0; frame_abort = 0;
    stat_rd = 0;
  endtask

  // advance the model by one edge from the present inputs
  task automatic model_step();
    logic [7:0] n;
    logic to_n, chg, ev;
    n = e_stat;
    if (tmr_zero && tmr_run_en && tmr_irq_en) n[7] = 1;
    else if (stat_rd) n[7] = 0;
    if (fsf_timeout) to_n = 1; else if (stat_rd) to_n = 0; else to_n = e_to;
    n[6] = (fsf_level >= fsf_thresh) || to_n;
    n[5] = (tx_level < tx_thresh);
    if (dma_tc_tx || dma_tc_rx) n[4] = 1; else if (stat_rd) n[4] = 0;
    chg = e_armed && (hs_value != e_prev);
    if (chg && (mode == 0 || ir_hs_en)) n[3] = 1; else if (hs_rd) n[3] = 0;
    if (mode <= 2) begin
      ev = (line_err != 0);
      if (ev) n[2] = 1; else if (usr_rd) n[2] = 0;
    end else if (mode == 3 || mode == 4) begin
      ev = frame_end || (frame_abort && rx_valid);
      if (ev) n[2] = 1; else if (stat_rd) n[2] = 0;
    end else n[2] = 0;
    n[1] = tx_empty;
    n[0] = rx_thresh;
    e_stat = n; e_to = to_n; e_prev = hs_value; e_armed = 1;
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    check_all();
  endtask

  task automatic randomize_inputs();
    quiet();
    if ($urandom % 20 == 0) mode = 3'($urandom % 8);
    ir_hs_en   = ($urandom % 2 == 0);
    tmr_zero   = ($urandom % 5 == 0);
    tmr_run_en = ($urandom % 3 != 0);
    tmr_irq_en = ($urandom % 3 != 0);
    fsf_level  = FW'($urandom); fsf_thresh = FW'($urandom);
    fsf_timeout = ($urandom % 8 == 0);
    tx_level   = TW'($urandom); tx_thresh = TW'($urandom);
    dma_tc_tx  = ($urandom % 9 == 0); dma_tc_rx = ($urandom % 9 == 0);
    if ($urandom % 4 == 0) hs_value = HW'($urandom);
    hs_rd      = ($urandom % 6 == 0);
    line_err   = ($urandom % 6 == 0) ? 4'(1 << ($urandom % 4)) : 4'h0;
    usr_rd     = ($urandom % 6 == 0);
    frame_end  = ($urandom % 10 == 0);
    frame_abort = ($urandom % 8 == 0);
    rx_valid   = ($urandom % 2 == 0);
    tx_empty   = ($urandom % 2 == 0); rx_thresh = ($urandom % 2 == 0);
    stat_rd    = ($urandom % 6 == 0);
    irq_en     = 8'($urandom);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    quiet();
    mode = 0; ir_hs_en = 0; tmr_run_en = 0; tmr_irq_en = 0;
    fsf_level = 0; fsf_thresh = 3'd1; tx_level = 3'd2; tx_thresh = 3'd1;
    hs_value = 0; rx_valid = 0; tx_empty = 0; rx_thresh = 0; irq_en = 8'hFF;
    e_stat = 0; e_to = 0; e_armed = 0; e_prev = 0;
    // R1: during reset
    repeat (3) @(negedge clk);
    check_all();
    rst_n = 1'b1;
    // R1: first cycle after release, all inputs quiet
    tick();

    // R2: timer gated by each enable, then set, then cleared by stat_rd
    tmr_zero = 1; tmr_run_en = 1; tmr_irq_en = 0; tick();
    tmr_run_en = 0; tmr_irq_en = 1; tick();
    tmr_run_en = 1; tick();
    tmr_zero = 0; stat_rd = 1; tick();
    // R12: set and clearing read together keep the bit
    dma_tc_rx = 1; tick();
    dma_tc_rx = 0; dma_tc_tx = 1; stat_rd = 1; tick();
    quiet(); stat_rd = 1; tick();
    // R3: threshold boundary and time-out pending below it
    quiet(); fsf_level = 3'd4; fsf_thresh = 3'd4; tick();
    fsf_level = 3'd3; tick();
    fsf_timeout = 1; tick();
    fsf_timeout = 0; tick();
    stat_rd = 1; tick();
    // R4: transmit threshold at equality and just below
    quiet(); tx_level = 3'd5; tx_thresh = 3'd5; tick();
    tx_level = 3'd4; tick();
    // R6/R7: handshake change in UART, blocked in IR without enable
    hs_value = 2'd1; tick();
    hs_value = 2'd2; mode = 3'd3; ir_hs_en = 0; hs_rd = 1; tick();
    hs_rd = 0; hs_value = 2'd3; ir_hs_en = 1; stat_rd = 1; tick();
    // R8: error group ignores stat_rd
    quiet(); mode = 3'd1; line_err = 4'b1000; tick();
    line_err = 0; stat_rd = 1; tick();
    stat_rd = 0; usr_rd = 1; tick();
    // R9: frame group; abort without valid data is ignored
    quiet(); mode = 3'd4; frame_abort = 1; rx_valid = 0; tick();
    rx_valid = 1; tick();
    frame_abort = 0; usr_rd = 1; tick();
    usr_rd = 0; frame_end = 1; mode = 3'd5; tick();
    // R10 and R11: levels and masking
    quiet(); tx_empty = 1; rx_thresh = 1; irq_en = 8'h00; tick();
    irq_en = 8'h01; @(negedge clk); check1("R11 irq", irq, exp_irq(e_stat, irq_en));
    tick();

    // random phase
    for (int k = 0; k < 3000; k++) begin
      randomize_inputs();
      tick();
    end
    if (seed == -1) $display("seed");
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule